// File: doc/BRIEF.md
# NAND Target Command Front End

This block sits on the device side of a parallel NAND bus. It watches the shared 8-bit I/O lines together with the latch-enable, chip-enable and strobe inputs, all sampled by the block's own clock. Each rising edge of the write strobe becomes one bus cycle. The block sorts each cycle into a command, an address or a data cycle. It collects multi-cycle addresses into a column and a row. It pairs setup codes with their confirm codes and sends one single-cycle request per completed sequence to a back end.

The back end performs the array operation and pulses `be_done` when it has finished. The front end holds the ready/busy line low from the cycle after a long operation is accepted until that pulse. While the line is low, only reset and the two status queries get through. The write-protect input blocks program and erase requests. Program data bytes are passed on one at a time as they arrive.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus cycle is taken only on a low-to-high transition of `we_n` with `ce_n` low and `re_n` high. CLE=1/ALE=0 is a command, ALE=1/CLE=0 is an address, and both low is data. A cycle with both high, with `ce_n` high or with `re_n` low has no effect.
- R2: In five-cycle sequences, byte 1 gives column bits 7..0. The low nibble of byte 2 gives column bits 11..8, and its high nibble must be zero or the sequence is discarded. Bytes 3, 4 and bit 0 of byte 5 give row bits 7..0, 15..8 and 16.
- R3: 00h, five addresses, 30h issues op 1 (read), and with 35h in place of 30h it issues op 2 (read for copy). After reset the block is in read mode, so five address cycles with no leading 00h followed by 30h also issue op 1.
- R4: 80h, five addresses, optional data, 10h issues op 3 (program) carrying the column and row of the first address. Each data cycle appears once on `dat_valid`/`dat_byte`. 85h from idle, five addresses, 10h issues op 4 (copy-back program).
- R5: 60h, three row cycles (row bits 7..0, 15..8, then bit 16), D0h issues op 5 (erase). 60h without a valid D0h issues nothing.
- R6: Inside a program, 85h followed by two address cycles issues op 10 (column change) on the next data cycle. In read mode, 05h, two address cycles, E0h issues op 10.
- R7: `rb_n` is high after reset. It goes low on the cycle the request appears for op 1, 2, 3, 4, 5 or 9, and goes high only on the clock after `be_done`.
- R8: While `rb_n` is low, only FFh, 70h and 78h produce a request. All other command, address and data cycles are ignored.
- R9: With `wp_n` low at the confirm, program, copy-back and erase confirms issue nothing and `rb_n` stays high.
- R10: FFh issues op 9 (reset) and returns to read mode. A further FFh while a reset is still busy issues nothing.
- R11: A confirm code without its setup code, or after the wrong number of address cycles, issues nothing and the interface returns to idle.
- R12: 70h issues op 6, 78h issues op 7 and 90h issues op 8. None of these changes `rb_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, low active |
| cle | input | 1 | Command latch level |
| ale | input | 1 | Address latch level |
| we_n | input | 1 | Write strobe, cycle taken on its rising edge |
| re_n | input | 1 | Read strobe, must be high for input cycles |
| wp_n | input | 1 | Write protect, low blocks program and erase |
| io_in | input | 8 | Command, address and data byte |
| be_done | input | 1 | Back end finished pulse |
| rb_n | output | 1 | Ready (1) / busy (0) |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Request code |
| req_col | output | 12 | Column of the request |
| req_row | output | 17 | Row of the request |
| dat_valid | output | 1 | Program data strobe |
| dat_byte | output | 8 | Program data byte |

## Verification
The assertions assume that the write strobe stays low for at least one clock and high for at least one clock. Under that assumption, two bus cycles can never arrive on adjacent clocks. They also assume that `be_done` comes only while the block is busy. The bench holds `we_n` low for two clocks and high for three on every cycle, and it changes `cle`, `ale`, `ce_n`, `re_n` and `io_in` only while the strobe is low. It pulses `be_done` only after a busy request has been seen.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {CK_CMD, CK_ADDR, CK_DATA} kind_e;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_READ = 4'd1, OP_READ_CB = 4'd2, OP_PROG = 4'd3,
    OP_COPYBACK = 4'd4, OP_ERASE = 4'd5, OP_STATUS = 4'd6, OP_STATUS_ENH = 4'd7,
    OP_ID = 4'd8, OP_RESET = 4'd9, OP_COLSET = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RADDR, S_PADDR, S_PDATA, S_EADDR, S_RCOL, S_PCOL
  } st_e;

  localparam logic [7:0] C_READ    = 8'h00;
  localparam logic [7:0] C_RDGO    = 8'h30;
  localparam logic [7:0] C_RDCB    = 8'h35;
  localparam logic [7:0] C_PROG    = 8'h80;
  localparam logic [7:0] C_PRGO    = 8'h10;
  localparam logic [7:0] C_MOVE    = 8'h85;
  localparam logic [7:0] C_ERASE   = 8'h60;
  localparam logic [7:0] C_ERGO    = 8'hD0;
  localparam logic [7:0] C_RCOL    = 8'h05;
  localparam logic [7:0] C_RCOLGO  = 8'hE0;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_STATX   = 8'h78;
  localparam logic [7:0] C_ID      = 8'h90;
  localparam logic [7:0] C_RESET   = 8'hFF;
endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
  import nand_fe_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic          re_n,
  input  logic          wp_n,
  input  logic [BW-1:0] io_in,
  output logic          ev_valid,
  output kind_e         ev_kind,
  output logic [BW-1:0] ev_byte,
  output logic          wp_ok
);
  logic we_q;
  logic edge_hit;

  assign edge_hit = we_n && !we_q && !ce_n && re_n && !(cle && ale);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q     <= 1'b1;
      ev_valid <= 1'b0;
      ev_kind  <= CK_DATA;
      ev_byte  <= '0;
      wp_ok    <= 1'b0;
    end else begin
      we_q     <= we_n;
      ev_valid <= edge_hit;
      wp_ok    <= wp_n;
      if (edge_hit) begin
        ev_byte <= io_in;
        if (cle)      ev_kind <= CK_CMD;
        else if (ale) ev_kind <= CK_ADDR;
        else          ev_kind <= CK_DATA;
      end
    end
  end

  // R1
  ev_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> !ev_valid);
endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
  parameter int NB = 5,
  parameter int CW = 12,
  parameter int RW = 17,
  localparam int CNTW = $clog2(NB + 2),
  localparam int CHI  = CW - 8,
  localparam int RHI  = RW - 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [CNTW-1:0] start,
  input  logic            push,
  input  logic [7:0]      byte_in,
  output logic [CNTW-1:0] cnt,
  output logic [CW-1:0]   col,
  output logic [RW-1:0]   row,
  output logic            col_ok
);
  localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};
  localparam logic [CNTW-1:0] NBV  = CNTW'(NB);

  logic [7:0]      ab [NB];
  logic [CNTW-1:0] wr_idx;
  logic            wr_en;

  assign wr_idx = clr ? start : cnt;
  assign wr_en  = push && (clr || cnt < NBV);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) ab[i] <= '0;
      else if (wr_en && wr_idx == CNTW'(i)) ab[i] <= byte_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (clr)                cnt <= push ? start + 1'b1 : start;
    else if (push && cnt != CMAX) cnt <= cnt + 1'b1;
  end

  assign col    = {ab[1][CHI-1:0], ab[0]};
  assign col_ok = (ab[1][7:CHI] == '0);
  assign row    = {ab[4][RHI-1:0], ab[3], ab[2]};

  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !clr && $past(!rst)) |=> (cnt != '0));
endmodule

// File: rtl/nand_cmd_fsm.sv
module nand_cmd_fsm
  import nand_fe_pkg::*;
#(
  parameter int CW = 12,
  parameter int RW = 17,
  parameter int NB = 5,
  localparam int CNTW = $clog2(NB + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid,
  input  kind_e           ev_kind,
  input  logic [7:0]      ev_byte,
  input  logic            wp_ok,
  input  logic            be_done,
  input  logic [CNTW-1:0] a_cnt,
  input  logic [CW-1:0]   a_col,
  input  logic [RW-1:0]   a_row,
  input  logic            a_col_ok,
  output logic            a_clr,
  output logic [CNTW-1:0] a_start,
  output logic            a_push,
  output logic            rb_n,
  output logic            req_valid,
  output logic [3:0]      req_op,
  output logic [CW-1:0]   req_col,
  output logic [RW-1:0]   req_row,
  output logic            dat_valid,
  output logic [7:0]      dat_byte
);
  localparam logic [CNTW-1:0] FULL = CNTW'(NB);
  localparam logic [CNTW-1:0] COLN = CNTW'(2);
  localparam logic [CNTW-1:0] ROW0 = CNTW'(2);

  st_e st, st_n;
  op_e bop, bop_n, fop;
  logic cb, cb_n, rmode, rmode_n, busy, busy_n, fire, dv, prog_ok;
  logic [CW-1:0] pcol, pcol_n, fcol;
  logic [RW-1:0] prow, prow_n, frow;

  assign busy    = !rb_n;
  assign prog_ok = (st == S_PDATA) || (st == S_PADDR && a_cnt == FULL && a_col_ok);

  always_comb begin
    st_n = st; bop_n = bop; cb_n = cb; rmode_n = rmode; busy_n = busy;
    pcol_n = pcol; prow_n = prow;
    fire = 1'b0; fop = OP_NONE; fcol = '0; frow = '0; dv = 1'b0;
    a_clr = 1'b0; a_start = '0; a_push = 1'b0;
    if (be_done) busy_n = 1'b0;
    if (ev_valid && busy) begin
      if (ev_kind == CK_CMD) begin
        case (ev_byte)
          C_RESET: if (bop != OP_RESET) begin
            fire = 1'b1; fop = OP_RESET; bop_n = OP_RESET; busy_n = 1'b1;
            st_n = S_IDLE; rmode_n = 1'b1;
          end
          C_STAT:  begin fire = 1'b1; fop = OP_STATUS; end
          C_STATX: begin fire = 1'b1; fop = OP_STATUS_ENH; end
          default: ;
        endcase
      end
    end else if (ev_valid) begin
      case (ev_kind)
        CK_CMD: begin
          st_n = S_IDLE;
          case (ev_byte)
            C_RESET: begin
              fire = 1'b1; fop = OP_RESET; bop_n = OP_RESET; busy_n = 1'b1; rmode_n = 1'b1;
            end
            C_STAT:  begin fire = 1'b1; fop = OP_STATUS; st_n = st; end
            C_STATX: begin fire = 1'b1; fop = OP_STATUS_ENH; st_n = st; end
            C_ID:    begin fire = 1'b1; fop = OP_ID; rmode_n = 1'b0; end
            C_READ:  begin st_n = S_RADDR; a_clr = 1'b1; rmode_n = 1'b1; end
            C_PROG:  begin st_n = S_PADDR; a_clr = 1'b1; cb_n = 1'b0; rmode_n = 1'b0; end
            C_ERASE: begin st_n = S_EADDR; a_clr = 1'b1; a_start = ROW0; rmode_n = 1'b0; end
            C_MOVE: begin
              a_clr = 1'b1; rmode_n = 1'b0;
              if (st == S_PDATA) st_n = S_PCOL;
              else begin st_n = S_PADDR; cb_n = 1'b1; end
            end
            C_RCOL: if (rmode && st == S_IDLE) begin st_n = S_RCOL; a_clr = 1'b1; end
            C_RDGO, C_RDCB: if (st == S_RADDR && a_cnt == FULL && a_col_ok) begin
              fire = 1'b1; fop = (ev_byte == C_RDGO) ? OP_READ : OP_READ_CB;
              bop_n = fop; busy_n = 1'b1; fcol = a_col; frow = a_row;
            end
            C_PRGO: if (prog_ok && wp_ok) begin
              fire = 1'b1; fop = cb ? OP_COPYBACK : OP_PROG; bop_n = fop; busy_n = 1'b1;
              fcol = (st == S_PDATA) ? pcol : a_col;
              frow = (st == S_PDATA) ? prow : a_row;
            end
            C_ERGO: if (st == S_EADDR && a_cnt == FULL && wp_ok) begin
              fire = 1'b1; fop = OP_ERASE; bop_n = OP_ERASE; busy_n = 1'b1; frow = a_row;
            end
            C_RCOLGO: if (st == S_RCOL && a_cnt == COLN) begin
              fire = 1'b1; fop = OP_COLSET; fcol = a_col;
            end
            default: ;
          endcase
        end
        CK_ADDR: begin
          if (st == S_RADDR || st == S_PADDR || st == S_EADDR || st == S_RCOL || st == S_PCOL)
            a_push = 1'b1;
          else if (st == S_IDLE && rmode) begin
            st_n = S_RADDR; a_clr = 1'b1; a_push = 1'b1;
          end
        end
        default: begin
          if (st == S_PADDR) begin
            if (a_cnt == FULL && a_col_ok) begin
              st_n = S_PDATA; pcol_n = a_col; prow_n = a_row; dv = 1'b1;
            end else st_n = S_IDLE;
          end else if (st == S_PDATA) dv = 1'b1;
          else if (st == S_PCOL) begin
            if (a_cnt == COLN) begin
              st_n = S_PDATA; dv = 1'b1; fire = 1'b1; fop = OP_COLSET; fcol = a_col;
            end else st_n = S_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bop <= OP_NONE; cb <= 1'b0; rmode <= 1'b1; rb_n <= 1'b1;
      pcol <= '0; prow <= '0;
      req_valid <= 1'b0; req_op <= '0; req_col <= '0; req_row <= '0;
      dat_valid <= 1'b0; dat_byte <= '0;
    end else begin
      st <= st_n; bop <= bop_n; cb <= cb_n; rmode <= rmode_n; rb_n <= !busy_n;
      pcol <= pcol_n; prow <= prow_n;
      req_valid <= fire; dat_valid <= dv;
      if (fire) begin req_op <= fop; req_col <= fcol; req_row <= frow; end
      if (dv) dat_byte <= ev_byte;
    end
  end

  // R7
  busy_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9})) |-> !rb_n);
  // R7
  ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_n) |-> $past(be_done));
  // R8
  busy_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !$past(rb_n)) |-> (req_op inside {4'd6, 4'd7, 4'd9}));
  // R9
  protect_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op inside {4'd3, 4'd4, 4'd5})) |-> $past(wp_ok));
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nand_fe_pkg::*;
#(
  parameter int CW = 12,
  parameter int RW = 17,
  parameter int NB = 5,
  localparam int CNTW = $clog2(NB + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          cle,
  input  logic          ale,
  input  logic          we_n,
  input  logic          re_n,
  input  logic          wp_n,
  input  logic [7:0]    io_in,
  input  logic          be_done,
  output logic          rb_n,
  output logic          req_valid,
  output logic [3:0]    req_op,
  output logic [CW-1:0] req_col,
  output logic [RW-1:0] req_row,
  output logic          dat_valid,
  output logic [7:0]    dat_byte
);
  logic            ev_valid, wp_ok, a_clr, a_push, a_col_ok;
  kind_e           ev_kind;
  logic [7:0]      ev_byte;
  logic [CNTW-1:0] a_start, a_cnt;
  logic [CW-1:0]   a_col;
  logic [RW-1:0]   a_row;

  nand_bus_sampler #(.BW(8)) u_samp (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .ev_byte(ev_byte), .wp_ok(wp_ok)
  );

  nand_addr_collect #(.NB(NB), .CW(CW), .RW(RW)) u_addr (
    .clk(clk), .rst(rst), .clr(a_clr), .start(a_start), .push(a_push),
    .byte_in(ev_byte), .cnt(a_cnt), .col(a_col), .row(a_row), .col_ok(a_col_ok)
  );

  nand_cmd_fsm #(.CW(CW), .RW(RW), .NB(NB)) u_fsm (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_byte(ev_byte),
    .wp_ok(wp_ok), .be_done(be_done), .a_cnt(a_cnt), .a_col(a_col), .a_row(a_row),
    .a_col_ok(a_col_ok), .a_clr(a_clr), .a_start(a_start), .a_push(a_push),
    .rb_n(rb_n), .req_valid(req_valid), .req_op(req_op), .req_col(req_col),
    .req_row(req_row), .dat_valid(dat_valid), .dat_byte(dat_byte)
  );
endmodule

// File: tb/nand_cmd_front_bench.sv
`timescale 1ns/1ps
module nand_cmd_front_bench;
  localparam real HALF = 2.0;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] io_in = '0;
  logic be_done = 1'b0;
  logic rb_n, req_valid, dat_valid;
  logic [3:0] req_op;
  logic [11:0] req_col;
  logic [16:0] req_row;
  logic [7:0] dat_byte;

  int checks = 0, fails = 0, nreq = 0, ndat = 0;
  logic [3:0] l_op; logic [11:0] l_col; logic [16:0] l_row; logic [7:0] l_dat;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  nand_cmd_front u_nand_cmd_front (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .wp_n(wp_n), .io_in(io_in), .be_done(be_done), .rb_n(rb_n), .req_valid(req_valid),
    .req_op(req_op), .req_col(req_col), .req_row(req_row), .dat_valid(dat_valid),
    .dat_byte(dat_byte)
  );

  always @(negedge clk) begin
    if (!rst && req_valid) begin nreq++; l_op = req_op; l_col = req_col; l_row = req_row; end
    if (!rst && dat_valid) begin ndat++; l_dat = dat_byte; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic a, input logic [7:0] b);
    @(posedge clk); #1;
    cle = c; ale = a; io_in = b; we_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 we_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [7:0] b); cyc(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b); cyc(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b); cyc(1'b0, 1'b0, b); endtask

  task automatic addr5(input logic [11:0] c, input logic [16:0] r);
    adr(c[7:0]); adr({4'h0, c[11:8]}); adr(r[7:0]); adr(r[15:8]); adr({7'h0, r[16]});
  endtask

  task automatic finish_op();
    @(posedge clk); #1 be_done = 1'b1;
    @(posedge clk); #1 be_done = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic expect_req(input string tag, input int base, input int op,
                            input int col, input int row);
    chk({tag, " count"}, nreq, base + 1);
    chk({tag, " op"}, l_op, op);
    chk({tag, " col"}, l_col, col);
    chk({tag, " row"}, l_row, row);
  endtask

  task automatic t_reset();
    chk("R7 reset rb_n", rb_n, 1);
    chk("R7 reset no request", nreq, 0);
  endtask

  task automatic t_powerup_read();
    int b = nreq;
    addr5(12'h234, 17'h1ABCD); cmd(8'h30);
    expect_req("R3 R2 power-up read", b, 1, 12'h234, 17'h1ABCD);
    chk("R7 busy after read", rb_n, 0);
  endtask

  task automatic t_busy_filter();
    int b = nreq;
    cmd(8'h90); adr(8'h11); dat(8'h22);
    chk("R8 ignored while busy", nreq, b);
    chk("R8 no data while busy", ndat, 0);
    cmd(8'h70); expect_req("R8 R12 status while busy", b, 6, 0, 0);
    cmd(8'h78); expect_req("R8 R12 enhanced status while busy", b + 1, 7, 0, 0);
    cmd(8'hFF); expect_req("R10 reset while busy", b + 2, 9, 0, 0);
    chk("R7 busy after reset", rb_n, 0);
    cmd(8'hFF);
    chk("R10 repeated reset ignored", nreq, b + 3);
    finish_op();
    chk("R7 ready after done", rb_n, 1);
  endtask

  task automatic t_id();
    int b = nreq;
    cmd(8'h90); expect_req("R12 id", b, 8, 0, 0);
    chk("R12 id keeps ready", rb_n, 1);
  endtask

  task automatic t_read_cb();
    int b = nreq;
    cmd(8'h00); addr5(12'hFFF, 17'h00040); cmd(8'h35);
    expect_req("R3 read for copy", b, 2, 12'hFFF, 17'h00040);
    chk("R7 busy after copy read", rb_n, 0);
    finish_op();
  endtask

  task automatic t_random_out();
    int b = nreq;
    cmd(8'h05); adr(8'h80); adr(8'h07); cmd(8'hE0);
    expect_req("R6 column change in read", b, 10, 12'h780, 0);
    chk("R6 column change keeps ready", rb_n, 1);
  endtask

  task automatic t_program();
    int b = nreq;
    int d = ndat;
    cmd(8'h80); addr5(12'h005, 17'h00123);
    dat(8'hA5); dat(8'h5A);
    chk("R4 data count", ndat, d + 2);
    chk("R4 data byte", l_dat, 8'h5A);
    cmd(8'h85); adr(8'h10); adr(8'h00); dat(8'h3C);
    expect_req("R6 column change in program", b, 10, 12'h010, 0);
    chk("R4 data after column change", l_dat, 8'h3C);
    cmd(8'h10);
    expect_req("R4 program", b + 1, 3, 12'h005, 17'h00123);
    chk("R7 busy after program", rb_n, 0);
    finish_op();
  endtask

  task automatic t_copyback();
    int b = nreq;
    cmd(8'h85); addr5(12'h000, 17'h00200); cmd(8'h10);
    expect_req("R4 copy-back program", b, 4, 0, 17'h00200);
    finish_op();
  endtask

  task automatic t_erase();
    int b = nreq;
    cmd(8'h60); adr(8'h41); adr(8'h02); adr(8'h01); cmd(8'hD0);
    expect_req("R5 erase", b, 5, 0, 17'h10241);
    chk("R7 busy after erase", rb_n, 0);
    finish_op();
  endtask

  task automatic t_lone_erase();
    int b = nreq;
    cmd(8'h60); cmd(8'h70);
    expect_req("R5 lone setup then status", b, 6, 0, 0);
    cmd(8'hD0);
    chk("R5 R11 erase confirm after short address", nreq, b + 1);
    chk("R5 still ready", rb_n, 1);
  endtask

  task automatic t_protect();
    int b = nreq;
    wp_n = 1'b0;
    cmd(8'h80); addr5(12'h001, 17'h00001); cmd(8'h10);
    chk("R9 program blocked", nreq, b);
    cmd(8'h60); adr(8'h01); adr(8'h00); adr(8'h00); cmd(8'hD0);
    chk("R9 erase blocked", nreq, b);
    chk("R9 stays ready", rb_n, 1);
    wp_n = 1'b1;
  endtask

  task automatic t_malformed();
    int b = nreq;
    cmd(8'h00); adr(8'h01); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'h30);
    chk("R11 read with four addresses", nreq, b);
    cmd(8'h00); adr(8'h34); adr(8'h12); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'h30);
    chk("R2 column high nibble nonzero", nreq, b);
    cmd(8'h10); cmd(8'hE0);
    chk("R11 confirms without setup", nreq, b);
    chk("R11 ready after discards", rb_n, 1);
  endtask

  task automatic t_qualify();
    int b = nreq;
    ce_n = 1'b1; cmd(8'h70); ce_n = 1'b0;
    chk("R1 chip deselected", nreq, b);
    re_n = 1'b0; cmd(8'h70); re_n = 1'b1;
    chk("R1 read strobe low", nreq, b);
    cyc(1'b1, 1'b1, 8'h70);
    chk("R1 both latches high", nreq, b);
    cmd(8'h70);
    expect_req("R1 qualified command", b, 6, 0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_powerup_read();
    t_busy_filter();
    t_id();
    t_read_cb();
    t_random_out();
    t_program();
    t_copyback();
    t_erase();
    t_lone_erase();
    t_protect();
    t_malformed();
    t_qualify();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(4.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule